// File: doc/BRIEF.md
# DMA Descriptor Condition and Next-Pointer Evaluator

This block serves one channel of a descriptor-driven DMA engine. When the channel finishes a descriptor, a one-cycle strobe asks the evaluator three questions about it: must the channel hold and retry this descriptor later, does it request an interrupt, and where does the next descriptor live. Each question is answered by a 2-bit mode field from the descriptor's command word. For two of those modes the answer depends on a condition: a masked comparison of the channel's four device-status bits against a select register that belongs to that question.

The results are registered and appear one cycle after the strobe. The next-descriptor pointer comes either from the descriptor's dependent-address word (a taken branch, which also sets a sticky branch-taken status bit) or from the current pointer plus the 16-byte descriptor size (a sequential step, which clears that bit). When the hold condition is met, the interrupt and branch decisions are suppressed for that strobe, and the pointer stays on the current descriptor so that it can be retried. The interrupt output is a single-cycle pulse that a sticky pending bit outside the block is expected to catch.

Top module: `dma_cond_eval`

## Requirements
- R1: While reset is high and in the first cycle after it, `result_valid`, `irq_pulse`, `wait_flag` and `branch_taken` are 0 and `next_ptr` is 0.
- R2: `result_valid` is high exactly in the cycle after each cycle in which `eval_strobe` was high, and low otherwise. `irq_pulse` is high only in a cycle where `result_valid` is high.
- R3: Each select register holds a 4-bit mask in bits 19:16 and a 4-bit compare value in bits 3:0. Its condition is true when (dev_status AND mask) equals (value AND mask). All other select bits are ignored.
- R4: Every mode field uses the same encoding: 00 never fires, 01 fires when the condition is true, 10 fires when the condition is false, 11 always fires. Each field uses its own select register: `intr_sel`, `branch_sel` or `wait_sel`.
- R5: `irq_pulse` is high for one cycle with the result when the interrupt mode fires and the wait mode does not.
- R6: When the wait mode fires, the result has `wait_flag` 1, `irq_pulse` 0 and `next_ptr` equal to the current pointer, and `branch_taken` keeps its previous value.
- R7: When the wait mode does not fire and the branch mode fires, `next_ptr` becomes `dep_addr` and `branch_taken` becomes 1.
- R8: When neither the wait mode nor the branch mode fires, `next_ptr` becomes `cur_ptr + 16`, wrapping modulo 2^32, and `branch_taken` becomes 0.
- R9: Branch mode 00 always produces the sequential step and mode 11 always produces the branch, whatever the status and the select registers hold.
- R10: `wait_flag` is updated on every strobe and returns to 0 on the first strobe whose wait mode does not fire.
- R11: Between strobes, `next_ptr`, `branch_taken` and `wait_flag` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eval_strobe | input | 1 | End of the current descriptor; evaluate this cycle |
| dev_status | input | 4 | Device-status bits of the channel |
| intr_sel | input | 32 | Interrupt select: mask in 19:16, value in 3:0 |
| branch_sel | input | 32 | Branch select: mask in 19:16, value in 3:0 |
| wait_sel | input | 32 | Wait select: mask in 19:16, value in 3:0 |
| intr_mode | input | 2 | Interrupt mode field of the command |
| branch_mode | input | 2 | Branch mode field of the command |
| wait_mode | input | 2 | Wait mode field of the command |
| cur_ptr | input | 32 | Address of the current descriptor |
| dep_addr | input | 32 | Dependent (branch target) address word of the descriptor |
| result_valid | output | 1 | One-cycle marker that the outputs below were just updated |
| irq_pulse | output | 1 | One-cycle interrupt request |
| wait_flag | output | 1 | Descriptor must be retried |
| branch_taken | output | 1 | Sticky branch-taken status bit |
| next_ptr | output | 32 | Address of the next descriptor |

## Verification
The embedded assertions check the timing on every cycle: the result marker follows the strobe by one cycle, the interrupt never coincides with a hold, and a held result leaves the pointer and the branch-taken bit unchanged. They also check that the sequential step is the previous pointer plus 16 and that a taken branch sets the status bit. Whether the masked compare reads the right select bits, whether each of the four modes fires in the right sense for each of the three fields, and whether the pointer wraps can only be shown by the bench's scenarios. These cover directed corner cases and a long run of random descriptors, all scored against a reference model.

// File: rtl/dma_cond_pkg.sv
package dma_cond_pkg;

    typedef enum logic [1:0] {
        MODE_NEVER  = 2'b00,
        MODE_IF_SET = 2'b01,
        MODE_IF_CLR = 2'b10,
        MODE_ALWAYS = 2'b11
    } cond_mode_e;

    // index of each decision inside the evaluator's condition array
    localparam int unsigned SLOT_INTR   = 0;
    localparam int unsigned SLOT_BRANCH = 1;
    localparam int unsigned SLOT_WAIT   = 2;
    localparam int unsigned NUM_SLOTS   = 3;

    typedef struct packed {
        logic irq;
        logic hold;
        logic take;
    } decision_t;

    function automatic logic mode_fires(input cond_mode_e mode, input logic cond);
        logic r;
        case (mode)
            MODE_NEVER:  r = 1'b0;
            MODE_IF_SET: r = cond;
            MODE_IF_CLR: r = ~cond;
            default:     r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dma_cond_match.sv
module dma_cond_match
    import dma_cond_pkg::*;
#(
    parameter int unsigned STAT_W   = 4,
    parameter int unsigned SEL_W    = 32,
    parameter int unsigned MASK_LSB = 16
) (
    input  logic [STAT_W-1:0] status,
    input  logic [SEL_W-1:0]  sel,
    input  logic [1:0]        mode,
    output logic              cond,
    output logic              fires
);
    localparam int unsigned MASK_MSB = MASK_LSB + STAT_W - 1;

    logic [STAT_W-1:0] mask;
    logic [STAT_W-1:0] value;

    always_comb begin
        mask  = sel[MASK_MSB:MASK_LSB];
        value = sel[STAT_W-1:0];
        cond  = ((status & mask) == (value & mask));
        fires = mode_fires(cond_mode_e'(mode), cond);
    end

endmodule

// File: rtl/dma_ptr_step.sv
module dma_ptr_step #(
    parameter int unsigned PTR_W      = 32,
    parameter int unsigned DESC_BYTES = 16
) (
    input  logic [PTR_W-1:0] cur_ptr,
    input  logic [PTR_W-1:0] dep_addr,
    input  logic             take,
    output logic [PTR_W-1:0] seq_ptr,
    output logic [PTR_W-1:0] next_ptr
);
    localparam logic [PTR_W-1:0] STEP = PTR_W'(DESC_BYTES);

    always_comb begin
        seq_ptr  = cur_ptr + STEP;
        next_ptr = take ? dep_addr : seq_ptr;
    end

endmodule

// File: rtl/dma_cond_eval.sv
module dma_cond_eval
    import dma_cond_pkg::*;
#(
    parameter int unsigned STAT_W     = 4,
    parameter int unsigned SEL_W      = 32,
    parameter int unsigned MASK_LSB   = 16,
    parameter int unsigned PTR_W      = 32,
    parameter int unsigned DESC_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              eval_strobe,
    input  logic [STAT_W-1:0] dev_status,
    input  logic [SEL_W-1:0]  intr_sel,
    input  logic [SEL_W-1:0]  branch_sel,
    input  logic [SEL_W-1:0]  wait_sel,
    input  logic [1:0]        intr_mode,
    input  logic [1:0]        branch_mode,
    input  logic [1:0]        wait_mode,
    input  logic [PTR_W-1:0]  cur_ptr,
    input  logic [PTR_W-1:0]  dep_addr,
    output logic              result_valid,
    output logic              irq_pulse,
    output logic              wait_flag,
    output logic              branch_taken,
    output logic [PTR_W-1:0]  next_ptr
);
    localparam logic [PTR_W-1:0] STEP = PTR_W'(DESC_BYTES);

    logic [NUM_SLOTS-1:0][SEL_W-1:0] sel_arr;
    logic [NUM_SLOTS-1:0][1:0]       mode_arr;
    logic [NUM_SLOTS-1:0]            cond_arr;
    logic [NUM_SLOTS-1:0]            fire_arr;

    assign sel_arr[SLOT_INTR]    = intr_sel;
    assign sel_arr[SLOT_BRANCH]  = branch_sel;
    assign sel_arr[SLOT_WAIT]    = wait_sel;
    assign mode_arr[SLOT_INTR]   = intr_mode;
    assign mode_arr[SLOT_BRANCH] = branch_mode;
    assign mode_arr[SLOT_WAIT]   = wait_mode;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        dma_cond_match #(
            .STAT_W  (STAT_W),
            .SEL_W   (SEL_W),
            .MASK_LSB(MASK_LSB)
        ) u_match (
            .status(dev_status),
            .sel   (sel_arr[g]),
            .mode  (mode_arr[g]),
            .cond  (cond_arr[g]),
            .fires (fire_arr[g])
        );
    end

    decision_t        dec;
    logic [PTR_W-1:0] seq_ptr;
    logic [PTR_W-1:0] step_ptr;

    always_comb begin
        dec.hold = fire_arr[SLOT_WAIT];
        dec.irq  = fire_arr[SLOT_INTR] & ~fire_arr[SLOT_WAIT];
        dec.take = fire_arr[SLOT_BRANCH];
    end

    dma_ptr_step #(
        .PTR_W     (PTR_W),
        .DESC_BYTES(DESC_BYTES)
    ) u_step (
        .cur_ptr (cur_ptr),
        .dep_addr(dep_addr),
        .take    (dec.take),
        .seq_ptr (seq_ptr),
        .next_ptr(step_ptr)
    );

    logic             valid_q;
    logic             irq_q;
    logic             hold_q;
    logic             bt_q;
    logic [PTR_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            irq_q   <= 1'b0;
            hold_q  <= 1'b0;
            bt_q    <= 1'b0;
            ptr_q   <= '0;
        end else begin
            valid_q <= eval_strobe;
            irq_q   <= eval_strobe & dec.irq;
            if (eval_strobe) begin
                hold_q <= dec.hold;
                if (dec.hold) begin
                    ptr_q <= cur_ptr;
                end else begin
                    ptr_q <= step_ptr;
                    bt_q  <= dec.take;
                end
            end
        end
    end

    assign result_valid = valid_q;
    assign irq_pulse    = irq_q;
    assign wait_flag    = hold_q;
    assign branch_taken = bt_q;
    assign next_ptr     = ptr_q;

    // R2
    strobe_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
        eval_strobe |=> result_valid);

    // R2
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !eval_strobe |=> !result_valid && !irq_pulse);

    // R5
    irq_not_on_hold_chk: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> result_valid && !wait_flag);

    // R6
    hold_keeps_state_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid && wait_flag |-> $stable(branch_taken) && next_ptr == $past(cur_ptr));

    // R8
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid && !wait_flag && !branch_taken |-> next_ptr == $past(cur_ptr) + STEP);

    // R7
    branch_load_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid && !wait_flag && branch_taken |-> next_ptr == $past(dep_addr));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !result_valid |-> $stable(next_ptr) && $stable(branch_taken) && $stable(wait_flag));

endmodule

// File: tb/dma_cond_eval_tb_top.sv
module dma_cond_eval_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        eval_strobe = 1'b0;
    logic [3:0]  dev_status = '0;
    logic [31:0] intr_sel = '0, branch_sel = '0, wait_sel = '0;
    logic [1:0]  intr_mode = '0, branch_mode = '0, wait_mode = '0;
    logic [31:0] cur_ptr = '0, dep_addr = '0;
    logic        result_valid, irq_pulse, wait_flag, branch_taken;
    logic [31:0] next_ptr;

    always #10 clk = ~clk;

    dma_cond_eval dut_i (
        .clk(clk), .rst(rst), .eval_strobe(eval_strobe), .dev_status(dev_status),
        .intr_sel(intr_sel), .branch_sel(branch_sel), .wait_sel(wait_sel),
        .intr_mode(intr_mode), .branch_mode(branch_mode), .wait_mode(wait_mode),
        .cur_ptr(cur_ptr), .dep_addr(dep_addr), .result_valid(result_valid),
        .irq_pulse(irq_pulse), .wait_flag(wait_flag), .branch_taken(branch_taken),
        .next_ptr(next_ptr)
    );

    typedef struct {
        logic        irq;
        logic        hold;
        logic        bt;
        logic [31:0] ptr;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int failures = 0;
    logic        m_bt = 1'b0;
    logic        m_hold = 1'b0;
    logic [31:0] m_ptr = '0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // R3 model: mask at 19:16, value at 3:0
    function automatic bit m_cond(input logic [3:0] st, input logic [31:0] sel);
        return (st & sel[19:16]) == (sel[3:0] & sel[19:16]);
    endfunction

    // R4 model: 00 never, 01 if true, 10 if false, 11 always
    function automatic bit m_fire(input logic [1:0] md, input bit c);
        case (md)
            2'b00: return 1'b0;
            2'b01: return c;
            2'b10: return !c;
            default: return 1'b1;
        endcase
    endfunction

    task automatic drive(input logic [3:0] st, input logic [31:0] isel, input logic [31:0] bsel,
                         input logic [31:0] wsel, input logic [1:0] im, input logic [1:0] bm,
                         input logic [1:0] wm, input logic [31:0] cp, input logic [31:0] da,
                         input string tag);
        exp_t e;
        bit hold, irq, take;
        @(negedge clk);
        dev_status = st; intr_sel = isel; branch_sel = bsel; wait_sel = wsel;
        intr_mode = im; branch_mode = bm; wait_mode = wm; cur_ptr = cp; dep_addr = da;
        eval_strobe = 1'b1;
        hold = m_fire(wm, m_cond(st, wsel));
        irq  = m_fire(im, m_cond(st, isel)) && !hold;
        take = m_fire(bm, m_cond(st, bsel));
        m_hold = hold;
        if (hold) m_ptr = cp;
        else begin
            m_ptr = take ? da : cp + 32'd16;
            m_bt = take;
        end
        e.irq = irq; e.hold = hold; e.bt = m_bt; e.ptr = m_ptr; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            eval_strobe = 1'b0;
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (result_valid) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R2 unexpected result_valid", 32'(result_valid), 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(irq_pulse == e.irq, {"R5 irq_pulse ", e.tag}, 32'(irq_pulse), 32'(e.irq));
                    chk(wait_flag == e.hold, {"R6/R10 wait_flag ", e.tag}, 32'(wait_flag), 32'(e.hold));
                    chk(branch_taken == e.bt, {"R7/R8 branch_taken ", e.tag}, 32'(branch_taken), 32'(e.bt));
                    chk(next_ptr == e.ptr, {"R7/R8 next_ptr ", e.tag}, next_ptr, e.ptr);
                end
            end else begin
                chk(irq_pulse == 1'b0, "R2 irq without result", 32'(irq_pulse), 32'd0);
            end
        end
    end

    initial begin
        #(20 * 100000);
        failures++;
        $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    localparam logic [31:0] M_ALL = 32'h000F_0000;

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state while in reset
        chk(!result_valid && !irq_pulse && !wait_flag && !branch_taken, "R1 flags in reset",
            {28'd0, result_valid, irq_pulse, wait_flag, branch_taken}, 32'd0);
        chk(next_ptr == 32'd0, "R1 next_ptr in reset", next_ptr, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!result_valid && !branch_taken && next_ptr == 0, "R1 after reset",
            next_ptr, 32'd0);

        // R9 never mode: sequential even when select matches
        drive(4'h5, 0, M_ALL | 32'h5, 0, 2'b00, 2'b00, 2'b00, 32'h1000, 32'h8000, "R9 never");
        // R9 always mode: branch even when condition false
        drive(4'h5, 0, M_ALL | 32'hA, 0, 2'b00, 2'b11, 2'b00, 32'h1010, 32'h2000, "R9 always");
        idle(2);
        // R11 idle hold
        chk(!result_valid && next_ptr == 32'h2000 && branch_taken, "R11 hold after idle",
            next_ptr, 32'h2000);
        // R4 if-set true / false, R3 mask
        drive(4'b1010, 0, 32'h000C_0008, 0, 2'b00, 2'b01, 2'b00, 32'h2000, 32'h3000, "R4 ifset true");
        drive(4'b1010, 0, 32'h000C_0004, 0, 2'b00, 2'b01, 2'b00, 32'h3000, 32'h4000, "R4 ifset false");
        drive(4'b1010, 0, 32'h000C_0004, 0, 2'b00, 2'b10, 2'b00, 32'h3010, 32'h5000, "R4 ifclr true");
        drive(4'b1010, 0, 32'h000C_0008, 0, 2'b00, 2'b10, 2'b00, 32'h5000, 32'h6000, "R4 ifclr false");
        // R3 junk in unused select bits ignored, mask zero => condition true
        drive(4'h3, 32'hFFF0_FFF0, 32'hFFF0_FFF0, 0, 2'b01, 2'b01, 2'b00, 32'h5010, 32'h7000, "R3 unused bits");
        // R5 interrupt modes
        drive(4'h1, M_ALL | 32'h1, 0, 0, 2'b01, 2'b00, 2'b00, 32'h7000, 0, "R5 irq ifset");
        drive(4'h1, M_ALL | 32'h2, 0, 0, 2'b10, 2'b00, 2'b00, 32'h7010, 0, "R5 irq ifclr");
        drive(4'h1, 0, 0, 0, 2'b11, 2'b00, 2'b00, 32'h7020, 0, "R5 irq always");
        drive(4'h1, 0, 0, 0, 2'b00, 2'b00, 2'b00, 32'h7030, 0, "R5 irq never");
        // set branch_taken, then R6 wait suppresses irq/branch and holds bt
        drive(4'h0, 0, 0, 0, 2'b00, 2'b11, 2'b00, 32'h7040, 32'h9000, "R7 set bt");
        drive(4'h6, 0, 0, M_ALL | 32'h6, 2'b11, 2'b00, 2'b01, 32'h9000, 32'hA000, "R6 wait ifset");
        drive(4'h6, 0, 0, 0, 2'b11, 2'b11, 2'b11, 32'h9000, 32'hA000, "R6 wait always");
        // R10 wait not firing clears flag
        drive(4'h6, 0, 0, M_ALL | 32'h6, 2'b00, 2'b00, 2'b10, 32'h9000, 32'hA000, "R10 wait clears");
        // R8 wrap
        drive(4'h0, 0, 0, 0, 2'b00, 2'b00, 2'b00, 32'hFFFF_FFF0, 32'h1, "R8 wrap");
        idle(3);
        chk(!result_valid && next_ptr == 32'h0 && !wait_flag, "R11 hold after wrap", next_ptr, 32'h0);
        // random run
        for (int i = 0; i < 400; i++) begin
            drive(4'($urandom), $urandom, $urandom, $urandom, 2'($urandom), 2'($urandom),
                  2'($urandom), $urandom & 32'hFFFF_FFF0, $urandom, "R4 random");
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
        end
        idle(4);
        chk(exp_q.size() == 0, "R2 results outstanding", 32'(exp_q.size()), 32'd0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule